// File: doc/BRIEF.md
# Parallel DAC Write-Cycle Timing Monitor

This block passively observes the control and data lines of a double-buffered, parallel-load DAC interface and reports write-cycle timing violations. The observed lines are an active-low chip select, an active-low write strobe, an active-low load strobe, an active-low converter reset and a parallel data bus. Each pin is sampled once per system clock. Every interval is measured as a count of samples. Each nanosecond limit is turned into a cycle count by rounding up against the clock-period parameter. A measured interval below that count is a violation.

Six rules are enforced:
- minimum low width on the select and load strobes;
- minimum low width on write and on the converter reset;
- the select or load strobe must already be low when write falls;
- the select or load strobe must stay low until write rises;
- data must be settled for a minimum time before write rises;
- data must be held for a minimum time after write rises.

Each rule sets its own sticky flag, and that flag clears only on the system reset. A one-cycle error strobe with a 3-bit rule code is raised in the cycle after the sample that broke a rule. The monitor never drives the bus.

Top module: `dac_wr_timing_chk`

## Requirements
- R1: While and after the system reset `rstN` is low, `violSticky`, `errStrobe` and `errCode` are all zero.
- R2: If `csN` or `ldacN` goes high after being low for fewer than ceil(STRB_WIDTH_NS / CLK_PERIOD_NS) samples (12 at defaults), code 1 is reported. A low run of exactly that length reports nothing.
- R3: If `wrN` or `dacRstN` goes high after being low for fewer than ceil(WR_WIDTH_NS / CLK_PERIOD_NS) samples (12 at defaults), code 2 is reported. Exactly that length reports nothing.
- R4: If `wrN` is first sampled low while both `csN` and `ldacN` are high, code 3 is reported. A strobe falling in the same sample as `wrN` is legal.
- R5: If both `csN` and `ldacN` become high while `wrN` is still low (and was low in the previous sample), code 4 is reported. A strobe rising in the same sample that `wrN` rises is legal.
- R6: Let N be the number of consecutive samples, ending just before the `wrN` rising sample, over which `dataBus` was unchanged. If N is below ceil(DATA_SETUP_NS / CLK_PERIOD_NS) (12 at defaults), code 5 is reported.
- R7: After the `wrN` rising sample k, `dataBus` must equal its value from sample k-1 in samples k through k+H-1, where H = ceil(DATA_HOLD_NS / CLK_PERIOD_NS) (2 at defaults). Otherwise code 6 is reported. A change at sample k+H is legal.
- R8: A violation in sample k raises `errStrobe` for exactly the following cycle, with `errCode` equal to the rule code. When several rules fail in one sample, the lowest code is shown. `errCode` is zero whenever `errStrobe` is low.
- R9: Bit (code-1) of `violSticky` is set by every violation of that rule and stays set until `rstN` goes low. All flags for simultaneous violations are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low asynchronous system reset; the only way to clear the flags |
| csN | input | 1 | Observed active-low chip select |
| wrN | input | 1 | Observed active-low write strobe |
| ldacN | input | 1 | Observed active-low load strobe |
| dacRstN | input | 1 | Observed active-low converter reset |
| dataBus | input | DATA_W | Observed parallel data |
| violSticky | output | 6 | Sticky per-rule flags; bit i holds rule code i+1 |
| errStrobe | output | 1 | One-cycle pulse for each sample with a violation |
| errCode | output | 3 | Code of the failed rule while `errStrobe` is high, else 0 |

## Verification
A wrong pulse-width or data-stability counter shows up as a strobe that fires, or fails to fire, on the cycle right after the closing edge of the interval. For that reason each limit is driven at exactly the minimum and at one sample short. A stale previous-sample register misplaces the write edges, which corrupts the strobe setup and hold codes on the first write that follows. A faulty hold window shows up only when data moves within the H samples after write rises, so changes are placed at offsets 0, 1 and H.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

  typedef enum logic [2:0] {
    RULE_NONE       = 3'd0,
    RULE_STRB_WIDTH = 3'd1,
    RULE_WR_WIDTH   = 3'd2,
    RULE_STRB_SETUP = 3'd3,
    RULE_STRB_HOLD  = 3'd4,
    RULE_DATA_SETUP = 3'd5,
    RULE_DATA_HOLD  = 3'd6
  } ruleE;

  localparam int NUM_RULES = 6;

  // observations from datapath to control
  typedef struct packed {
    logic wrFall;
    logic wrRise;
    logic wrLow;
    logic wrLowPrev;
    logic strbIdle;
    logic strbIdlePrev;
    logic strbWidthShort;
    logic wrWidthShort;
    logic dataSetupShort;
    logic dataMovedNow;
    logic dataMovedHeld;
  } obsT;

  // strobes from control to datapath
  typedef struct packed {
    logic captureEdge;
  } ctlT;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/dwc_datapath.sv
module dwc_datapath
  import dwc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STRB_CYC  = 12,
  parameter int WR_CYC    = 12,
  parameter int SETUP_CYC = 12,
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              ldacN,
  input  logic              dacRstN,
  input  logic [DATA_W-1:0] dataBus,
  input  ctlT               ctl,
  output obsT               obs
);

  localparam int NPIN = 4;  // 0 cs, 1 ldac, 2 wr, 3 converter reset
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] SETUP_LIM = CNT_W'(SETUP_CYC);

  logic [NPIN-1:0]   pinNow;
  logic [NPIN-1:0]   pinPrev;
  logic [NPIN-1:0]   shortRise;
  logic [DATA_W-1:0] dataPrev;
  logic [DATA_W-1:0] heldData;
  logic [CNT_W-1:0]  runLen;
  logic              idlePrev;

  assign pinNow = {dacRstN, wrN, ldacN, csN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev  <= '1;
      idlePrev <= 1'b1;
    end else begin
      pinPrev  <= pinNow;
      idlePrev <= csN & ldacN;
    end
  end

  // low-run counter per observed pin
  for (genvar i = 0; i < NPIN; i++) begin : g_width
    localparam logic [CNT_W-1:0] MIN_LOW = CNT_W'((i < 2) ? STRB_CYC : WR_CYC);
    logic [CNT_W-1:0] lowCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           lowCnt <= '0;
      else if (!pinNow[i]) lowCnt <= (lowCnt == CNT_MAX) ? lowCnt : lowCnt + 1'b1;
      else                 lowCnt <= '0;
    end

    assign shortRise[i] = pinNow[i] & ~pinPrev[i] & (lowCnt < MIN_LOW);
  end

  // data stability run length and edge capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataPrev <= '0;
      runLen   <= '0;
      heldData <= '0;
    end else begin
      dataPrev <= dataBus;
      if (dataBus != dataPrev) runLen <= CNT_W'(1);
      else if (runLen != CNT_MAX) runLen <= runLen + 1'b1;
      if (ctl.captureEdge) heldData <= dataPrev;
    end
  end

  always_comb begin
    obs.wrFall         = ~wrN & pinPrev[2];
    obs.wrRise         = wrN & ~pinPrev[2];
    obs.wrLow          = ~wrN;
    obs.wrLowPrev      = ~pinPrev[2];
    obs.strbIdle       = csN & ldacN;
    obs.strbIdlePrev   = idlePrev;
    obs.strbWidthShort = shortRise[0] | shortRise[1];
    obs.wrWidthShort   = shortRise[2] | shortRise[3];
    obs.dataSetupShort = wrN & ~pinPrev[2] & (runLen < SETUP_LIM);
    obs.dataMovedNow   = dataBus != dataPrev;
    obs.dataMovedHeld  = dataBus != heldData;
  end

endmodule

// File: rtl/dwc_control.sv
module dwc_control
  import dwc_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  obsT                  obs,
  output ctlT                  ctl,
  output logic [NUM_RULES-1:0] violSticky,
  output logic                 errStrobe,
  output logic [2:0]           errCode
);

  localparam int HW = $clog2(HOLD_CYC + 1) + 1;
  localparam logic [HW-1:0] HOLD_RELOAD = (HOLD_CYC > 0) ? HW'(HOLD_CYC - 1) : '0;
  localparam bit HOLD_ON = HOLD_CYC > 0;

  logic [HW-1:0]        holdLeft;
  logic [NUM_RULES-1:0] viol;
  logic [2:0]           codeNext;
  logic                 windowOpen;

  assign windowOpen = holdLeft != '0;
  assign ctl.captureEdge = obs.wrRise;

  always_comb begin
    viol = '0;
    viol[RULE_STRB_WIDTH - 1] = obs.strbWidthShort;
    viol[RULE_WR_WIDTH - 1]   = obs.wrWidthShort;
    viol[RULE_STRB_SETUP - 1] = obs.wrFall & obs.strbIdle;
    viol[RULE_STRB_HOLD - 1]  = obs.wrLow & obs.wrLowPrev & obs.strbIdle & ~obs.strbIdlePrev;
    viol[RULE_DATA_SETUP - 1] = obs.dataSetupShort;
    viol[RULE_DATA_HOLD - 1]  = HOLD_ON & ((obs.wrRise & obs.dataMovedNow) |
                                           (~obs.wrRise & windowOpen & obs.dataMovedHeld));
  end

  always_comb begin
    codeNext = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--)
      if (viol[i]) codeNext = 3'(i + 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdLeft <= '0;
    end else if (obs.wrRise) begin
      holdLeft <= obs.dataMovedNow ? '0 : HOLD_RELOAD;
    end else if (windowOpen) begin
      holdLeft <= obs.dataMovedHeld ? '0 : holdLeft - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violSticky <= '0;
      errStrobe  <= 1'b0;
      errCode    <= '0;
    end else begin
      violSticky <= violSticky | viol;
      errStrobe  <= |viol;
      errCode    <= codeNext;
    end
  end

endmodule

// File: rtl/dac_wr_timing_chk.sv
module dac_wr_timing_chk
  import dwc_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int STRB_WIDTH_NS = 90,
  parameter int WR_WIDTH_NS   = 90,
  parameter int DATA_SETUP_NS = 90,
  parameter int DATA_HOLD_NS  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              ldacN,
  input  logic              dacRstN,
  input  logic [DATA_W-1:0] dataBus,
  output logic [5:0]        violSticky,
  output logic              errStrobe,
  output logic [2:0]        errCode
);

  localparam int STRB_CYC  = ceilDiv(STRB_WIDTH_NS, CLK_PERIOD_NS);
  localparam int WR_CYC    = ceilDiv(WR_WIDTH_NS, CLK_PERIOD_NS);
  localparam int SETUP_CYC = ceilDiv(DATA_SETUP_NS, CLK_PERIOD_NS);
  localparam int HOLD_CYC  = ceilDiv(DATA_HOLD_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC   = (STRB_CYC > WR_CYC) ?
                             ((STRB_CYC > SETUP_CYC) ? STRB_CYC : SETUP_CYC) :
                             ((WR_CYC > SETUP_CYC) ? WR_CYC : SETUP_CYC);
  localparam int CNT_W     = $clog2(MAX_CYC + 1) + 1;

  obsT obs;
  ctlT ctl;

  dwc_datapath #(
    .DATA_W(DATA_W), .STRB_CYC(STRB_CYC), .WR_CYC(WR_CYC),
    .SETUP_CYC(SETUP_CYC), .CNT_W(CNT_W)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .ldacN(ldacN),
    .dacRstN(dacRstN), .dataBus(dataBus), .ctl(ctl), .obs(obs)
  );

  dwc_control #(
    .HOLD_CYC(HOLD_CYC)
  ) control_i (
    .clk(clk), .rstN(rstN), .obs(obs), .ctl(ctl),
    .violSticky(violSticky), .errStrobe(errStrobe), .errCode(errCode)
  );

endmodule

// File: rtl/dwc_checker.sv
module dwc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       wrN,
  input logic       ldacN,
  input logic [5:0] violSticky,
  input logic       errStrobe,
  input logic [2:0] errCode
);

  p_code_with_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |-> (errCode != 3'd0 && errCode <= 3'd6));

  p_code_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !errStrobe |-> errCode == 3'd0);

  p_strobe_sets_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |-> violSticky[errCode - 3'd1]);

  p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (violSticky & $past(violSticky)) == $past(violSticky));

  p_strobe_setup_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !wrN && $past(wrN) && csN && ldacN) |=> violSticky[2]);

  p_strobe_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !wrN && !$past(wrN) && csN && ldacN && !($past(csN) && $past(ldacN)))
      |=> violSticky[3]);

  always_ff @(posedge clk)
    if (!rstN) p_reset_quiet_r1: assert (violSticky == 6'd0 || $past(!rstN) == 1'b0);

endmodule

bind dac_wr_timing_chk dwc_checker chk_i (.*);

// File: tb/dac_wr_timing_chk_tb.sv
module dac_wr_timing_chk_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, wrN = 1'b1, ldacN = 1'b1, dacRstN = 1'b1;
  logic [7:0] dataBus = 8'h00;
  logic [5:0] violSticky;
  logic       errStrobe;
  logic [2:0] errCode;

  int   vectors = 0;
  int   miscompares = 0;
  bit   finished = 0;
  int   expQ[$];
  string reqQ[$];
  logic [5:0] expSticky = '0;

  // limits derived from the requirements at an 8 ns clock
  localparam int MIN_W = 12;
  localparam int SETUP = 12;
  localparam int HOLD  = 2;

  always #4 clk = ~clk;

  dac_wr_timing_chk dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .ldacN(ldacN),
    .dacRstN(dacRstN), .dataBus(dataBus),
    .violSticky(violSticky), .errStrobe(errStrobe), .errCode(errCode)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pushExp(input int code, input string req);
    expQ.push_back(code);
    reqQ.push_back(req);
    expSticky |= 6'(1 << (code - 1));
  endtask

  // monitor: pop and compare each strobe as it appears
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (errStrobe) begin
        if (expQ.size() == 0) check(1'b0, "R8", "unexpected strobe code", int'(errCode), 0);
        else begin
          int c;
          string r;
          c = expQ.pop_front();
          r = reqQ.pop_front();
          check(int'(errCode) == c, r, "strobe code", int'(errCode), c);
        end
      end else if (errCode != 3'd0) begin
        check(1'b0, "R8", "code without strobe", int'(errCode), 0);
      end
    end
  end

  task automatic groupEnd(input string req);
    step(4);
    check(expQ.size() == 0, req, "missing strobes", expQ.size(), 0);
    expQ.delete();
    reqQ.delete();
    check(violSticky == expSticky, req, "sticky flags", int'(violSticky), int'(expSticky));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(2);
    check(violSticky == 6'd0 && errStrobe == 1'b0 && errCode == 3'd0, "R1",
          "outputs in reset", int'({violSticky, errStrobe, errCode}), 0);
    rstN = 1'b1;
    expSticky = '0;
    step(20);
    check(violSticky == 6'd0, "R9", "flags after reset", int'(violSticky), 0);
  endtask

  task automatic pulseLow(input int pin, input int n);
    case (pin)
      0: csN = 1'b0; 1: ldacN = 1'b0; default: dacRstN = 1'b0;
    endcase
    step(n);
    csN = 1'b1; ldacN = 1'b1; dacRstN = 1'b1;
    step(3);
  endtask

  // strobe and write fall together, data set setupN samples before rise,
  // data moves holdM samples after the rise sample
  task automatic writeCycle(input logic [7:0] v, input int setupN, input int holdM,
                            input bit viaLdac);
    if (viaLdac) ldacN = 1'b0; else csN = 1'b0;
    wrN = 1'b0;
    step(14);
    dataBus = v;
    step(setupN);
    wrN = 1'b1; csN = 1'b1; ldacN = 1'b1;
    if (holdM > 0) step(holdM);
    dataBus = ~v;
    step(3);
  endtask

  initial begin
    doReset();

    // R2: strobe widths
    pulseLow(0, MIN_W);
    pushExp(1, "R2"); pulseLow(0, MIN_W - 1);
    pushExp(1, "R2"); pulseLow(1, MIN_W - 1);
    pulseLow(1, MIN_W);
    groupEnd("R2");
    step(30);
    check(violSticky == expSticky, "R9", "flag held while idle", int'(violSticky), int'(expSticky));
    doReset();

    // R3: write and converter-reset widths
    pushExp(2, "R3"); pulseLow(3, MIN_W - 1);
    pulseLow(3, MIN_W);
    csN = 1'b0; step(1); wrN = 1'b0; step(MIN_W - 1);
    pushExp(2, "R3"); wrN = 1'b1; step(1); csN = 1'b1; step(3);
    csN = 1'b0; step(1); wrN = 1'b0; step(MIN_W);
    wrN = 1'b1; step(1); csN = 1'b1; step(3);
    groupEnd("R3");
    doReset();

    // R4: strobe setup to write fall
    writeCycle(8'h3C, SETUP, HOLD, 1'b0);
    pushExp(3, "R4"); wrN = 1'b0; step(1); csN = 1'b0; step(14);
    wrN = 1'b1; csN = 1'b1; step(4);
    groupEnd("R4");
    doReset();

    // R5: strobe hold to write rise
    csN = 1'b0; wrN = 1'b0; step(MIN_W + 1);
    pushExp(4, "R5"); csN = 1'b1; step(1); wrN = 1'b1; step(4);
    writeCycle(8'hA5, SETUP, HOLD, 1'b1);
    groupEnd("R5");
    doReset();

    // R6: data setup
    writeCycle(8'h11, SETUP, HOLD, 1'b0);
    pushExp(5, "R6"); writeCycle(8'h22, SETUP - 1, HOLD, 1'b0);
    pushExp(5, "R6"); writeCycle(8'h44, 1, HOLD, 1'b1);
    groupEnd("R6");
    doReset();

    // R7: data hold
    writeCycle(8'h55, SETUP, HOLD, 1'b0);
    pushExp(6, "R7"); writeCycle(8'h66, SETUP, HOLD - 1, 1'b0);
    pushExp(6, "R7"); writeCycle(8'h77, SETUP, 0, 1'b0);
    groupEnd("R7");
    doReset();

    // R8: simultaneous setup and hold failures show the lower code
    pushExp(5, "R8");
    expSticky |= 6'b100000;
    writeCycle(8'h99, SETUP - 3, 0, 1'b0);
    groupEnd("R8");
    doReset();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule